// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block takes one internal operand transfer of one to four bytes and carries it out as one or more cycles on an external bus. The slave's data width can be 8, 16 or 32 bits. The width is not known in advance. The slave reports it at the end of every cycle through a two-bit acknowledge code, and that code may differ from one cycle to the next within a single transfer. Each external cycle drives three things: the current byte address, a two-bit code giving the bytes still owed for the whole operand, and a read/write level.

On writes, the sequencer places every outgoing byte on each data lane that any of the three port widths would sample, so that the slave finds correct data whatever its width. On reads, it collects the bytes that the slave returns on its lanes into the operand register. It signals completion with a one-clock pulse once nothing is left to move.

The operand is big-endian and right-aligned. For an N-byte operand, the byte at the lowest address is the most significant of the N low bytes of the operand word. Lane 0 is data bits 31..24 and lane 3 is bits 7..0.

Top module: `dbs_sequencer`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its size, address, direction and data are latched then. A `req_valid` seen during a transfer has no effect on that transfer.
- R2: During a cycle, `bus_siz` gives the bytes remaining in the whole operand: 01 means one, 10 means two, 11 means three and 00 means four. The same encoding is used for `req_size`.
- R3: A cycle moves min(remaining, P − (address mod P)) bytes, where P is the acknowledged port width in bytes. `bus_addr` then advances by that count and the remaining count drops by it.
- R4: `bus_cyc` is high in every cycle of a transfer and low otherwise. `bus_rw` is 1 for a read and 0 for a write.
- R5: An acknowledge of 00 leaves the cycle open with address and size unchanged. The codes 01, 10 and 11 end the cycle as an 8-, 16- or 32-bit port respectively.
- R6: On a write, each of the three port widths finds the right operand bytes on its own lanes. A 32-bit port uses lanes starting at lane (address mod 4). A 16-bit port uses lanes starting at lane (address mod 2). An 8-bit port uses lane 0.
- R7: During a write cycle, a lane that no port width would sample is driven zero. Outside write cycles, `bus_wdata` is all zero.
- R8: On a read, each returned byte is taken from the lane given by the acknowledged width and offset, as in R6. `rd_data` holds the operand right-aligned with the lowest-address byte most significant, and lanes the port does not use are ignored.
- R9: `done` is high for exactly one clock, the clock after the cycle that moved the last byte. The block is idle on the clock after that.
- R10: The port width may change from one cycle to the next within a transfer. Each cycle's byte count uses that cycle's acknowledge.
- R11: Address stepping carries across long-word boundaries into the upper address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Idle, able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size, encoded as for `bus_siz` |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-aligned |
| bus_cyc | output | 1 | External cycle in progress |
| bus_addr | output | ADDR_W | Current byte address |
| bus_siz | output | 2 | Remaining-byte code |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 32 | Routed and duplicated write lanes |
| bus_ack | input | 2 | 00 wait, 01 8-bit, 10 16-bit, 11 32-bit |
| bus_rdata | input | 32 | Read lanes from the slave |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read operand |

## Verification
The hardest case to reach is a misaligned read whose port width changes partway through. In that case the lane base, the byte count and the operand slot all move at once, and each depends on the previous cycle's outcome. The bench's slave model picks a width for each cycle in turn, for example 16-bit and then 32-bit, starting from an odd address. It fills the lanes the port does not use with a junk pattern, so a byte taken from the wrong lane shows up in `rd_data`. A second hard case is a write that lands on a lane three of the widths disagree about. To reach it, the bench starts writes at every offset and checks each width's view of the lanes separately.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        ACK_WAIT = 2'b00,
        ACK_P8   = 2'b01,
        ACK_P16  = 2'b10,
        ACK_P32  = 2'b11
    } ack_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUSY = 2'b01,
        ST_FIN  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic [2:0] nbytes;
        logic [1:0] lane_base;
    } beat_t;

    function automatic logic [2:0] siz_to_count(logic [1:0] s);
        return (s == 2'b00) ? 3'd4 : {1'b0, s};
    endfunction

    function automatic logic [1:0] count_to_siz(logic [2:0] c);
        return (c == 3'd4) ? 2'b00 : c[1:0];
    endfunction

endpackage

// File: rtl/dbs_beat_calc.sv
module dbs_beat_calc
    import dbs_pkg::*;
(
    input  logic [1:0] ack,
    input  logic [1:0] off,
    input  logic [2:0] rem,
    output beat_t      beat
);
    logic [2:0] room;

    always_comb begin
        room           = 3'd0;
        beat.lane_base = 2'd0;
        unique case (ack)
            ACK_P32: begin
                room           = 3'd4 - {1'b0, off};
                beat.lane_base = off;
            end
            ACK_P16: begin
                room           = 3'd2 - {2'b00, off[0]};
                beat.lane_base = {1'b0, off[0]};
            end
            ACK_P8: begin
                room           = 3'd1;
                beat.lane_base = 2'd0;
            end
            default: begin
                room           = 3'd0;
                beat.lane_base = 2'd0;
            end
        endcase
        beat.nbytes = (rem < room) ? rem : room;
    end
endmodule

// File: rtl/dbs_wr_router.sv
module dbs_wr_router
    import dbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    en,
    input  logic [BYTE_W-1:0]       op [LANES],
    input  logic [1:0]              idx,
    input  logic [1:0]              off,
    input  logic [2:0]              rem,
    output logic [LANES*BYTE_W-1:0] wdata
);
    logic [BYTE_W-1:0] lane_v [LANES];

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        localparam logic [2:0] LPOS = 3'(L);
        logic [2:0] d32;
        logic [2:0] d16;
        logic       hit32;
        logic       hit16;

        always_comb begin
            d32   = LPOS - {1'b0, off};
            d16   = LPOS - {2'b00, off[0]};
            hit32 = (LPOS >= {1'b0, off}) && (d32 < rem);
            hit16 = (L < 2) && (LPOS >= {2'b00, off[0]}) && (d16 < rem);
            if (!en)
                lane_v[L] = '0;
            else if (hit32)
                lane_v[L] = op[idx + d32[1:0]];
            else if (hit16)
                lane_v[L] = op[idx + d16[1:0]];
            else if (L == 0)
                lane_v[L] = op[idx];
            else
                lane_v[L] = '0;
        end

        assign wdata[BYTE_W*(LANES-1-L) +: BYTE_W] = lane_v[L];
    end
endmodule

// File: rtl/dbs_rd_gather.sv
module dbs_rd_gather
    import dbs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    capture,
    input  beat_t                   beat,
    input  logic [1:0]              idx,
    input  logic [LANES*BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0]       op [LANES]
);
    for (genvar J = 0; J < LANES; J++) begin : g_slot
        localparam logic [1:0] JPOS = 2'(J);
        logic [1:0] k;
        logic [1:0] lane;
        logic       take;

        always_comb begin
            k    = JPOS - idx;
            lane = beat.lane_base + k;
            take = capture && (JPOS >= idx) && ({1'b0, k} < beat.nbytes);
        end

        always_ff @(posedge clk) begin
            if (rst || clear)
                op[J] <= '0;
            else if (take)
                op[J] <= rdata[BYTE_W*(LANES-1-int'(lane)) +: BYTE_W];
        end
    end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*BYTE_W-1:0] req_wdata,
    output logic                    bus_cyc,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [1:0]              bus_siz,
    output logic                    bus_rw,
    output logic [LANES*BYTE_W-1:0] bus_wdata,
    input  logic [1:0]              bus_ack,
    input  logic [LANES*BYTE_W-1:0] bus_rdata,
    output logic                    done,
    output logic [LANES*BYTE_W-1:0] rd_data
);
    localparam int DATA_W = LANES * BYTE_W;

    seq_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        rem_q;
    logic [2:0]        size_q;
    logic [1:0]        idx_q;
    logic              wr_q;
    logic [BYTE_W-1:0] opw_q   [LANES];
    logic [BYTE_W-1:0] op_rd   [LANES];
    logic [BYTE_W-1:0] req_byte[LANES];
    logic [2:0]        req_cnt;
    beat_t             beat;
    logic              accept;
    logic              ack_any;
    logic              last;

    assign req_cnt = siz_to_count(req_size);
    assign accept  = (st_q == ST_IDLE) && req_valid;
    assign ack_any = bus_cyc && (bus_ack != ACK_WAIT);
    assign last    = (beat.nbytes == rem_q);

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            req_byte[j] = '0;
            if (j < int'(req_cnt))
                req_byte[j] = req_wdata[BYTE_W*(int'(req_cnt)-1-j) +: BYTE_W];
        end
    end

    dbs_beat_calc u_calc (
        .ack  (bus_ack),
        .off  (addr_q[1:0]),
        .rem  (rem_q),
        .beat (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            rem_q  <= '0;
            size_q <= '0;
            idx_q  <= '0;
            wr_q   <= 1'b0;
            for (int j = 0; j < LANES; j++) opw_q[j] <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    st_q   <= ST_BUSY;
                    addr_q <= req_addr;
                    rem_q  <= req_cnt;
                    size_q <= req_cnt;
                    idx_q  <= 2'd0;
                    wr_q   <= req_write;
                    for (int j = 0; j < LANES; j++) opw_q[j] <= req_byte[j];
                end
                ST_BUSY: if (ack_any) begin
                    addr_q <= addr_q + ADDR_W'(beat.nbytes);
                    rem_q  <= rem_q - beat.nbytes;
                    idx_q  <= idx_q + beat.nbytes[1:0];
                    if (last) st_q <= ST_FIN;
                end
                ST_FIN:  st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    dbs_wr_router #(.BYTE_W(BYTE_W)) u_router (
        .en    (bus_cyc && wr_q),
        .op    (opw_q),
        .idx   (idx_q),
        .off   (addr_q[1:0]),
        .rem   (rem_q),
        .wdata (bus_wdata)
    );

    dbs_rd_gather #(.BYTE_W(BYTE_W)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (ack_any && !wr_q),
        .beat    (beat),
        .idx     (idx_q),
        .rdata   (bus_rdata),
        .op      (op_rd)
    );

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(size_q))
                rd_data[BYTE_W*(int'(size_q)-1-j) +: BYTE_W] = op_rd[j];
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign bus_cyc   = (st_q == ST_BUSY);
    assign done      = (st_q == ST_FIN);
    assign bus_addr  = addr_q;
    assign bus_siz   = count_to_siz(rem_q);
    assign bus_rw    = !wr_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_cyc && !done); // R1
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && bus_ack == 2'b00 |=> bus_cyc && $stable(bus_addr) && $stable(bus_siz)); // R5
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        ack_any |-> beat.nbytes != 3'd0 && beat.nbytes <= rem_q); // R3
    AST_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        ack_any |=> done || (bus_addr != $past(bus_addr))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready); // R9
    AST_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
        bus_cyc && !bus_rw |-> bus_wdata[DATA_W-1 -: BYTE_W] == opw_q[idx_q]); // R6
endmodule

// File: tb/dbs_sequencer_tb.sv
module dbs_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        bus_cyc;
    logic [31:0] bus_addr;
    logic [1:0]  bus_siz;
    logic        bus_rw;
    logic [31:0] bus_wdata;
    logic [1:0]  bus_ack = 2'b00;
    logic [31:0] bus_rdata = '0;
    logic        done;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc_n  = 0;
    logic [7:0] mem [64];

    always #2.5 clk = ~clk;

    dbs_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
        .bus_siz(bus_siz), .bus_rw(bus_rw), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (cyc_n == 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=<50000 cycles", cyc_n);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] siz_code(input int n);
        return (n == 4) ? 2'b00 : 2'(n);
    endfunction

    function automatic logic [1:0] ack_code(input int w);
        return (w == 4) ? 2'b11 : (w == 2) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [7:0] lane_of(input logic [31:0] d, input int l);
        return d[31-8*l -: 8];
    endfunction

    // One transfer. w holds the port width in bytes for each cycle in turn.
    task automatic xfer(input bit wr, input int n, input logic [31:0] a,
                        input logic [31:0] wd, input int w [4],
                        input bit waits, input bit junk, input string tag);
        logic [31:0] cur = a;
        logic [31:0] exp_rd = '0;
        logic [7:0]  opb [4];
        int rem = n;
        int idx = 0;
        int beat = 0;
        for (int j = 0; j < 4; j++) opb[j] = (j < n) ? wd[8*(n-1-j) +: 8] : 8'h00;
        for (int j = 0; j < n; j++) exp_rd[8*(n-1-j) +: 8] = mem[(a + j) & 63];

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = siz_code(n);
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 32'hDEAD_BEEF;

        while (rem > 0) begin
            int pw  = w[beat];
            int off = int'(cur % pw);
            int nb  = (rem < pw - off) ? rem : pw - off;
            logic [31:0] rdat = 32'hEEEE_EEEE;
            bit used [4];
            chk(bus_cyc == 1'b1, "R4", {tag, " cyc high"}, 32'(bus_cyc), 32'd1);
            chk(bus_rw == !wr, "R4", {tag, " rw level"}, 32'(bus_rw), 32'(!wr));
            chk(bus_addr == cur, "R3", {tag, " address"}, bus_addr, cur);
            chk(bus_siz == siz_code(rem), "R2", {tag, " size code"}, 32'(bus_siz), 32'(siz_code(rem)));
            if (wr) begin
                for (int l = 0; l < 4; l++) used[l] = 1'b0;
                for (int wi = 0; wi < 3; wi++) begin
                    int ww  = (wi == 0) ? 1 : (wi == 1) ? 2 : 4;
                    int wo  = int'(cur % ww);
                    int wn  = (rem < ww - wo) ? rem : ww - wo;
                    int wb  = (ww == 4) ? wo : (ww == 2) ? wo : 0;
                    for (int k = 0; k < wn; k++) begin
                        used[wb + k] = 1'b1;
                        chk(lane_of(bus_wdata, wb + k) == opb[idx + k], "R6",
                            $sformatf("%s width %0d lane %0d", tag, ww * 8, wb + k),
                            32'(lane_of(bus_wdata, wb + k)), 32'(opb[idx + k]));
                    end
                end
                for (int l = 0; l < 4; l++)
                    if (!used[l])
                        chk(lane_of(bus_wdata, l) == 8'h00, "R7",
                            $sformatf("%s idle lane %0d", tag, l),
                            32'(lane_of(bus_wdata, l)), 32'h0);
            end else begin
                chk(bus_wdata == 32'h0, "R7", {tag, " wdata zero on read"}, bus_wdata, 32'h0);
            end

            if (waits && beat == 0) begin
                bus_ack = 2'b00;
                if (junk) begin
                    req_valid = 1'b1; req_write = !wr; req_size = 2'b01;
                    req_addr = 32'h0000_0033; req_wdata = 32'h1111_1111;
                end
                @(negedge clk);
                req_valid = 1'b0;
                chk(bus_cyc && bus_addr == cur, "R5", {tag, " wait holds address"}, bus_addr, cur);
                chk(bus_siz == siz_code(rem), "R5", {tag, " wait holds size"}, 32'(bus_siz), 32'(siz_code(rem)));
                if (junk)
                    chk(bus_rw == !wr, "R1", {tag, " busy request ignored"}, 32'(bus_rw), 32'(!wr));
            end

            for (int l = 0; l < pw; l++)
                rdat[31-8*l -: 8] = mem[(cur - 32'(off) + 32'(l)) & 63];
            if (wr)
                for (int k = 0; k < nb; k++)
                    mem[(cur + 32'(k)) & 63] = lane_of(bus_wdata, ((pw == 1) ? 0 : off) + k);
            bus_ack = ack_code(pw);
            bus_rdata = rdat;
            @(negedge clk);
            bus_ack = 2'b00;
            bus_rdata = 32'hEEEE_EEEE;
            cur = cur + 32'(nb);
            rem = rem - nb;
            idx = idx + nb;
            beat = beat + 1;
            if (rem > 0)
                chk(done == 1'b0, "R9", {tag, " no early done"}, 32'(done), 32'd0);
        end
        chk(done == 1'b1, "R9", {tag, " done pulse"}, 32'(done), 32'd1);
        chk(bus_cyc == 1'b0, "R4", {tag, " cyc low after"}, 32'(bus_cyc), 32'd0);
        if (!wr)
            chk(rd_data == exp_rd, "R8", {tag, " read operand"}, rd_data, exp_rd);
        @(negedge clk);
        chk(done == 1'b0, "R9", {tag, " done one clock"}, 32'(done), 32'd0);
        chk(req_ready == 1'b1, "R1", {tag, " idle again"}, 32'(req_ready), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
        chk(bus_cyc == 1'b0, "R4", "reset cyc", 32'(bus_cyc), 32'd0);
        chk(done == 1'b0, "R9", "reset done", 32'(done), 32'd0);
        chk(bus_wdata == 32'h0, "R7", "reset wdata", bus_wdata, 32'h0);
        rst = 1'b0;

        xfer(1, 4, 32'h0000_0010, 32'hA1B2_C3D4, '{4, 4, 4, 4}, 0, 0, "R3 long 32");
        xfer(1, 4, 32'h0000_0020, 32'h1122_3344, '{2, 2, 2, 2}, 0, 0, "R3 long 16");
        xfer(1, 4, 32'h0000_0028, 32'h5566_7788, '{1, 1, 1, 1}, 0, 0, "R2 long 8");
        xfer(1, 1, 32'h0000_0007, 32'h0000_00C7, '{4, 4, 4, 4}, 0, 0, "R6 byte off3");
        xfer(1, 3, 32'h0000_0031, 32'h00AB_CDEF, '{4, 4, 4, 4}, 0, 0, "R6 tri off1");
        xfer(1, 2, 32'h0000_0036, 32'h0000_9A9B, '{2, 2, 2, 2}, 1, 1, "R5 R1 wait");
        xfer(0, 4, 32'h0000_0020, 32'h0, '{4, 4, 4, 4}, 0, 0, "R8 readback 16w");
        xfer(0, 2, 32'h0000_0031, 32'h0, '{4, 4, 4, 4}, 0, 0, "R8 word off1");
        xfer(0, 3, 32'h0000_0013, 32'h0, '{4, 4, 4, 4}, 0, 0, "R8 tri off3");
        xfer(0, 4, 32'h0000_0029, 32'h0, '{2, 4, 4, 4}, 0, 0, "R10 width change");
        xfer(0, 4, 32'h0000_0005, 32'h0, '{1, 2, 4, 4}, 1, 0, "R10 8-16-32");
        xfer(0, 4, 32'h0000_00FE, 32'h0, '{4, 4, 4, 4}, 0, 0, "R11 carry");
        xfer(1, 4, 32'h0001_FFFF, 32'hCAFE_F00D, '{2, 4, 4, 4}, 0, 0, "R11 write carry");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule